// File: doc/BRIEF.md
# Banked GPIO Register Interface

This block is the register file of a general-purpose I/O controller serving 128 pins, organised as four banks of 32. Each bank holds a direction word, an output latch and two alternate-function words. Software changes the latch only through two write-only aliases: one sets the bits written as 1, the other clears them. A level register returns, per bit, the latch for output pins and the sampled pad value for input pins.

A plain synchronous bus reaches the registers with a byte offset, a one-cycle write strobe and a read strobe. Read data is registered and appears one cycle after the read strobe. The pin side drives each output as the latch bit gated by its direction bit. Each pin also has a change strobe that pulses for one cycle whenever its driven value changes. A read of any level register raises a one-cycle notify pulse. Edge detection, interrupts and the actual alternate-function muxing live elsewhere. The alternate-function words are only stored here.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every direction, latch and alternate-function word is zero, so all pins are inputs. `pin_out`, `pin_chg`, `bus_rdata` and `lvl_rd_pulse` are all zero.
- R2: The direction and alternate-function words are read/write and return the last value written to them.
- R3: A write to a bank's set alias ORs the written data into that bank's output latch.
- R4: A write to a bank's clear alias clears every latch bit that is 1 in the written data.
- R5: A read of a set or clear alias returns zero.
- R6: A level read returns, bit by bit, the latch where direction is 1 and the sampled input where direction is 0. Inputs are sampled by one register stage, so a pin change is visible to a level read issued one cycle later. Writes to the level register have no effect.
- R7: `pin_out` equals latch AND direction for every pin. `pin_chg` is 1 for exactly the pins whose `pin_out` changed, during the cycle right after the write edge, and is 0 otherwise.
- R8: Offset map, for banks b = 0..2:
  - level at 0x000+4b, direction at 0x00C+4b, set at 0x018+4b, clear at 0x024+4b;
  - bank 3 uses each bank-0 offset plus 0x100;
  - lower alternate-function words at 0x054+8b and upper words at 0x058+8b, for b = 0..3.
- R9: Accesses at offsets of 0x200 or above change nothing and read zero. So do offsets below 0x200 that are unaligned or unmapped, including 0x030 to 0x050.
- R10: `bus_rdata` updates only on the edge where `bus_rd` is high. It holds its value on cycles without a read.
- R11: A level read makes `lvl_rd_pulse` 1 for exactly the one cycle in which its data is presented. Other reads leave it 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_off | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 128 | Sampled pad input levels |
| pin_out | output | 128 | Driven pin values (latch AND direction) |
| pin_chg | output | 128 | Per-pin one-cycle strobe on a change of pin_out |
| lvl_rd_pulse | output | 1 | One-cycle notify after a level read |

## Verification
Random writes hit every alias of every bank. Because set and clear accumulate into the latch, a model that treated them as plain stores would miss bits. Random pad values combined with random direction words exercise the level merge, showing whether each bit follows its own direction. Offsets drawn over the whole 12-bit range check the region above 0x200 against the folded bank-3 window, which shows whether a decoder drops the top address bits. Directed cases cover the bank-3 aliases, unaligned and edge-register offsets, the hold of read data, and the single-cycle width of both pulses.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BANKS  = 4;
    localparam int BANK_W = $clog2(BANKS);

    typedef enum logic [2:0] {
        REG_NONE,
        REG_LEVEL,
        REG_DIR,
        REG_SET,
        REG_CLR,
        REG_AFLO,
        REG_AFHI
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e           kind;
        logic [BANK_W-1:0]   bank;
    } reg_sel_t;

endpackage

// File: rtl/gpio_off_decode.sv
module gpio_off_decode
    import gpio_bank_pkg::*;
#(
    parameter int OFF_W = 12
) (
    input  logic [OFF_W-1:0] off_i,
    output reg_sel_t         sel_o
);

    logic [3:0] idx;
    logic [7:0] af_rel;
    logic [2:0] af_k;

    always_comb begin
        sel_o.kind = REG_NONE;
        sel_o.bank = '0;
        idx        = off_i[5:2];
        af_rel     = off_i[7:0] - 8'h54;
        af_k       = af_rel[4:2];
        // offsets from 0x200 upward and unaligned offsets decode to nothing
        if (!(|off_i[OFF_W-1:9]) && off_i[1:0] == 2'b00) begin
            if (!off_i[8]) begin
                if (off_i[7:0] <= 8'h2C) begin
                    // three consecutive words per register type, banks 0..2
                    if (idx >= 4'd9) begin
                        sel_o.kind = REG_CLR;
                        sel_o.bank = BANK_W'(idx - 4'd9);
                    end else if (idx >= 4'd6) begin
                        sel_o.kind = REG_SET;
                        sel_o.bank = BANK_W'(idx - 4'd6);
                    end else if (idx >= 4'd3) begin
                        sel_o.kind = REG_DIR;
                        sel_o.bank = BANK_W'(idx - 4'd3);
                    end else begin
                        sel_o.kind = REG_LEVEL;
                        sel_o.bank = BANK_W'(idx);
                    end
                end else if (off_i[7:0] >= 8'h54 && off_i[7:0] <= 8'h70) begin
                    // interleaved lower/upper alternate-function words
                    sel_o.kind = af_k[0] ? REG_AFHI : REG_AFLO;
                    sel_o.bank = BANK_W'(af_k[2:1]);
                end
            end else begin
                // bank 3 window, folded 0x100 above bank 0
                sel_o.bank = BANK_W'(3);
                case (off_i[7:0])
                    8'h00:   sel_o.kind = REG_LEVEL;
                    8'h0C:   sel_o.kind = REG_DIR;
                    8'h18:   sel_o.kind = REG_SET;
                    8'h24:   sel_o.kind = REG_CLR;
                    default: begin
                        sel_o.kind = REG_NONE;
                        sel_o.bank = '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_bank_slice.sv
module gpio_bank_slice #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_dir,
    input  logic              we_set,
    input  logic              we_clr,
    input  logic              we_aflo,
    input  logic              we_afhi,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dir_o,
    output logic [DATA_W-1:0] lat_o,
    output logic [DATA_W-1:0] aflo_o,
    output logic [DATA_W-1:0] afhi_o,
    output logic [DATA_W-1:0] drv_o
);

    typedef struct packed {
        logic [DATA_W-1:0] dir;
        logic [DATA_W-1:0] lat;
        logic [DATA_W-1:0] aflo;
        logic [DATA_W-1:0] afhi;
    } slice_st_t;

    slice_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_dir)  st_d.dir  = wdata;
        if (we_set)  st_d.lat  = st_q.lat | wdata;
        if (we_clr)  st_d.lat  = st_q.lat & ~wdata;
        if (we_aflo) st_d.aflo = wdata;
        if (we_afhi) st_d.afhi = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_o  = st_q.dir;
    assign lat_o  = st_q.lat;
    assign aflo_o = st_q.aflo;
    assign afhi_o = st_q.afhi;
    assign drv_o  = st_q.lat & st_q.dir;

    // R3
    set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_set |=> ((lat_o & $past(wdata)) == $past(wdata)) &&
                   ((lat_o & ~$past(wdata)) == ($past(lat_o) & ~$past(wdata))));

    // R4
    clr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_clr |=> ((lat_o & $past(wdata)) == '0) &&
                   ((lat_o & ~$past(wdata)) == ($past(lat_o) & ~$past(wdata))));

    // R7
    drv_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_o & ~dir_o) == '0);

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [OFF_W-1:0]         bus_off,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [BANKS*DATA_W-1:0]  pin_in,
    output logic [BANKS*DATA_W-1:0]  pin_out,
    output logic [BANKS*DATA_W-1:0]  pin_chg,
    output logic                     lvl_rd_pulse
);

    localparam int NPINS = BANKS * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              pulse;
        logic [NPINS-1:0]  in_smp;
        logic [NPINS-1:0]  prev;
    } top_st_t;

    top_st_t  st_d, st_q;
    reg_sel_t sel;

    logic [DATA_W-1:0] dir_a  [BANKS];
    logic [DATA_W-1:0] lat_a  [BANKS];
    logic [DATA_W-1:0] aflo_a [BANKS];
    logic [DATA_W-1:0] afhi_a [BANKS];
    logic [DATA_W-1:0] in_a   [BANKS];
    logic [NPINS-1:0]  dir_flat;
    logic [NPINS-1:0]  lat_flat;
    logic [DATA_W-1:0] rd_val;

    gpio_off_decode #(.OFF_W(OFF_W)) i_dec (
        .off_i (bus_off),
        .sel_o (sel)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic hit;
        assign hit = bus_wr && (sel.bank == BANK_W'(b));

        gpio_bank_slice #(.DATA_W(DATA_W)) i_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_dir  (hit && sel.kind == REG_DIR),
            .we_set  (hit && sel.kind == REG_SET),
            .we_clr  (hit && sel.kind == REG_CLR),
            .we_aflo (hit && sel.kind == REG_AFLO),
            .we_afhi (hit && sel.kind == REG_AFHI),
            .wdata   (bus_wdata),
            .dir_o   (dir_a[b]),
            .lat_o   (lat_a[b]),
            .aflo_o  (aflo_a[b]),
            .afhi_o  (afhi_a[b]),
            .drv_o   (pin_out[b*DATA_W +: DATA_W])
        );

        assign in_a[b]                       = st_q.in_smp[b*DATA_W +: DATA_W];
        assign dir_flat[b*DATA_W +: DATA_W]  = dir_a[b];
        assign lat_flat[b*DATA_W +: DATA_W]  = lat_a[b];
    end

    always_comb begin
        case (sel.kind)
            REG_LEVEL: rd_val = (lat_a[sel.bank] & dir_a[sel.bank]) |
                                (in_a[sel.bank] & ~dir_a[sel.bank]);
            REG_DIR:   rd_val = dir_a[sel.bank];
            REG_AFLO:  rd_val = aflo_a[sel.bank];
            REG_AFHI:  rd_val = afhi_a[sel.bank];
            default:   rd_val = '0;
        endcase
    end

    always_comb begin
        st_d        = st_q;
        st_d.rdata  = bus_rd ? rd_val : st_q.rdata;
        st_d.pulse  = bus_rd && (sel.kind == REG_LEVEL);
        st_d.in_smp = pin_in;
        st_d.prev   = pin_out;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata    = st_q.rdata;
    assign lvl_rd_pulse = st_q.pulse;
    assign pin_chg      = pin_out ^ st_q.prev;

    // R9
    hi_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && |bus_off[OFF_W-1:9]) |=> $stable(dir_flat) && $stable(lat_flat));

    // R9
    hi_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && |bus_off[OFF_W-1:9]) |=> bus_rdata == '0);

    // R5
    wo_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (sel.kind == REG_SET || sel.kind == REG_CLR)) |=> bus_rdata == '0);

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R11
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_rd_pulse && !(bus_rd && sel.kind == REG_LEVEL)) |=> !lvl_rd_pulse);

endmodule

// File: tb/test_gpio_bank_regs.sv
module test_gpio_bank_regs;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [11:0]  bus_off = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] pin_in = '0;
    logic [127:0] pin_out;
    logic [127:0] pin_chg;
    logic         lvl_rd_pulse;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] dir_m  [4];
    logic [31:0] lat_m  [4];
    logic [31:0] aflo_m [4];
    logic [31:0] afhi_m [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank_regs i_gpio_bank_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_off      (bus_off),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .pin_in       (pin_in),
        .pin_out      (pin_out),
        .pin_chg      (pin_chg),
        .lvl_rd_pulse (lvl_rd_pulse)
    );

    // kinds: 0 level, 1 dir, 2 set, 3 clear, 4 af lower, 5 af upper (R8)
    function automatic logic [11:0] off_of(int k, int b);
        if (k == 4) return 12'(12'h054 + 8*b);
        if (k == 5) return 12'(12'h058 + 8*b);
        if (b == 3) return 12'(12'h100 + 12*k);
        return 12'(12*k + 4*b);
    endfunction

    function automatic logic [127:0] drive_m();
        logic [127:0] v;
        for (int b = 0; b < 4; b++) v[b*32 +: 32] = lat_m[b] & dir_m[b];
        return v;
    endfunction

    function automatic logic [31:0] read_m(logic [11:0] off, output bit is_lvl);
        is_lvl = 1'b0;
        for (int b = 0; b < 4; b++)
            for (int k = 0; k < 6; k++)
                if (off == off_of(k, b)) begin
                    case (k)
                        0: begin
                            is_lvl = 1'b1;
                            return (lat_m[b] & dir_m[b]) | (pin_in[b*32 +: 32] & ~dir_m[b]);
                        end
                        1: return dir_m[b];
                        4: return aflo_m[b];
                        5: return afhi_m[b];
                        default: return 32'h0;
                    endcase
                end
        return 32'h0;
    endfunction

    task automatic model_wr(logic [11:0] off, logic [31:0] d);
        for (int b = 0; b < 4; b++)
            for (int k = 0; k < 6; k++)
                if (off == off_of(k, b)) begin
                    case (k)
                        1: dir_m[b]  = d;
                        2: lat_m[b]  = lat_m[b] | d;
                        3: lat_m[b]  = lat_m[b] & ~d;
                        4: aflo_m[b] = d;
                        5: afhi_m[b] = d;
                        default: ;
                    endcase
                end
    endtask

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive a write, then check pin_out and pin_chg in the following cycle (R7)
    task automatic do_wr(logic [11:0] off, logic [31:0] d, string req);
        logic [127:0] old_drv, new_drv;
        old_drv = drive_m();
        @(negedge clk);
        bus_wr = 1'b1; bus_off = off; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_wr(off, d);
        new_drv = drive_m();
        chk({req, " R7 pin_out"}, pin_out, new_drv);
        chk({req, " R7 pin_chg"}, pin_chg, old_drv ^ new_drv);
    endtask

    task automatic do_rd(logic [11:0] off, string req);
        logic [31:0] exp;
        bit          lvl;
        exp = read_m(off, lvl);
        @(negedge clk);
        bus_rd = 1'b1; bus_off = off;
        @(negedge clk);
        bus_rd = 1'b0;
        chk({req, " rdata"}, 128'(bus_rdata), 128'(exp));
        chk({req, " R11 pulse"}, 128'(lvl_rd_pulse), 128'(lvl));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold;
        for (int b = 0; b < 4; b++) begin
            dir_m[b] = '0; lat_m[b] = '0; aflo_m[b] = '0; afhi_m[b] = '0;
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 pin_out", pin_out, '0);
        chk("R1 pin_chg", pin_chg, '0);
        chk("R1 rdata", 128'(bus_rdata), '0);
        chk("R1 pulse", 128'(lvl_rd_pulse), '0);
        for (int b = 0; b < 4; b++) do_rd(off_of(1, b), "R1 dir");
        do_rd(off_of(4, 2), "R1 aflo");

        // R2, R8 read/write words at every bank
        for (int b = 0; b < 4; b++) begin
            do_wr(off_of(4, b), 32'hA000_0000 | b, "R2 aflo");
            do_wr(off_of(5, b), 32'h5000_0000 | b, "R2 afhi");
        end
        for (int b = 0; b < 4; b++) begin
            do_rd(off_of(4, b), "R8 aflo");
            do_rd(off_of(5, b), "R8 afhi");
        end

        // R3, R4, R5 on bank 3 through the folded window
        do_wr(12'h10C, 32'hFFFF_0000, "R8 bank3 dir");
        do_wr(12'h118, 32'h00FF_FF00, "R3 set");
        do_wr(12'h118, 32'h0000_00F0, "R3 set accumulate");
        do_wr(12'h124, 32'h000F_0F00, "R4 clear");
        do_rd(12'h118, "R5 set read");
        do_rd(12'h124, "R5 clear read");
        do_rd(12'h100, "R6 bank3 level");
        chk("R7 pin_chg one cycle", pin_chg, '0);

        // R6 level merge; writes to level ignored
        @(negedge clk);
        pin_in = {4{32'h1234_5678}};
        @(negedge clk);
        do_rd(12'h100, "R6 merge");
        do_wr(12'h000, 32'hFFFF_FFFF, "R6 level write");
        do_rd(12'h000, "R6 level after write");

        // R9 ignored offsets
        do_wr(12'h20C, 32'hDEAD_BEEF, "R9 high write");
        do_wr(12'h30C, 32'hDEAD_BEEF, "R9 high fold write");
        do_wr(12'h00D, 32'hDEAD_BEEF, "R9 unaligned write");
        do_wr(12'h030, 32'hDEAD_BEEF, "R9 edge region write");
        do_rd(12'h00C, "R9 dir unchanged");
        do_rd(12'h10C, "R9 bank3 dir unchanged");
        do_rd(12'h300, "R9 high read");
        do_rd(12'h030, "R9 edge region read");
        do_rd(12'h10D, "R9 unaligned read");

        // R10 hold and R11 single pulse
        do_rd(12'h008, "R10 prime");
        hold = bus_rdata;
        @(negedge clk);
        chk("R10 hold", 128'(bus_rdata), 128'(hold));
        chk("R11 pulse low", 128'(lvl_rd_pulse), '0);

        // constrained random mix
        for (int i = 0; i < 500; i++) begin
            int op;
            op = int'($urandom % 10);
            if (op < 4) begin
                do_wr(off_of(int'($urandom % 6), int'($urandom % 4)), $urandom, "R3/R4 rand wr");
            end else if (op < 7) begin
                do_rd(off_of(int'($urandom % 6), int'($urandom % 4)), "R6/R8 rand rd");
            end else if (op == 7) begin
                @(negedge clk);
                pin_in = {$urandom, $urandom, $urandom, $urandom};
                @(negedge clk);
            end else begin
                logic [11:0] ro;
                ro = 12'($urandom);
                do_wr(ro, $urandom, "R9 rand wr");
                do_rd(ro, "R9 rand rd");
            end
        end
        for (int b = 0; b < 4; b++) do_rd(off_of(1, b), "R2 final dir");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule